// File: doc/BRIEF.md
# Tiled 2D Address Generator

This block turns a pixel coordinate into a 32-bit address inside a tiled view window. Each request carries an x and a y coordinate, a two-bit pixel format code and a three-bit orientation code. The block checks the coordinate against the range of the chosen format. It then mirrors x and/or y by XOR with the field mask and optionally swaps the roles of x and y. It packs the two fields into a linear offset, scales the offset by the pixel size of the format, and places the format and orientation codes in the top address bits. Alongside the address it reports the line stride for that format and orientation, plus a flag that marks a coordinate as outside the window. It does no translation to physical memory.

Requests enter through a valid/ready handshake. The result is registered and appears exactly one cycle after the request is accepted. A small control machine has three states:
- ST_INIT is the reset state and is not ready. It always moves to ST_IDLE on the next clock.
- ST_IDLE moves to ST_ISSUE when a request is accepted, and otherwise stays.
- ST_ISSUE drives the result valid. It stays in ST_ISSUE on a further accept, and returns to ST_IDLE when no request is accepted.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is asserted, and for the first cycle after it is released, in_ready is 0. During reset, out_valid, out_addr, out_stride and out_oor are all 0. in_ready is 1 from the second cycle after release onward.
- R2: Address bits [28:27] carry the format code: 0 = 8-bit tiled, 1 = 16-bit tiled, 2 = 32-bit tiled, 3 = page mode.
- R3: Address bits [31:29] carry the orientation code. Bit 0 of the code inverts x, bit 1 inverts y and bit 2 swaps x and y. This gives 0 = 0°, 1 = 180° mirrored, 2 = 0° mirrored, 3 = 180°, 4 = 270° mirrored, 5 = 270°, 6 = 90°, 7 = 90° mirrored.
- R4: The (x-shift, y-shift) pair is (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. For page mode it is (SLOT_W_BITS, SLOT_H_BITS), which defaults to (6,6). The x field width is CONT_W_BITS (default 14) minus the x-shift; the y field width is CONT_H_BITS (default 13) minus the y-shift.
- R5: A coordinate is in range when x is at most the x mask and y is at most the y mask, where each mask is all ones over its field width. Any coordinate beyond its mask forces out_addr to 0 and out_oor to 1. A coordinate exactly at the mask is in range.
- R6: When the x-invert flag is set, x is XORed with the x mask before packing. When the y-invert flag is set, y is XORed with the y mask.
- R7: Without swap, the offset is (y << x field width) + x. With swap, it is (x << y field width) + y.
- R8: The packed offset is shifted left by x-shift + y-shift before the format and orientation fields are inserted. For example, page mode at x=1, y=0 with orientation 0 gives 0x18001000.
- R9: out_stride is 1 << (CONT_H_BITS + x-shift) when swap is set, and 1 << (CONT_W_BITS + y-shift) otherwise. It is valid for out-of-range coordinates too.
- R10: The result of a request accepted at a clock edge is on the outputs after that edge, with out_valid high. In a cycle after an edge with no accept, out_valid is 0 and out_addr, out_stride and out_oor keep their previous values.
- R11: Requests can be accepted on consecutive cycles. Each one produces its own result one cycle later, with out_valid held high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_fmt | input | 2 | Pixel format code |
| in_orient | input | 3 | Orientation code |
| in_x | input | COORD_W | Pixel x coordinate |
| in_y | input | COORD_W | Pixel y coordinate |
| out_valid | output | 1 | Result valid |
| out_addr | output | ADDR_W | Tiled view address |
| out_stride | output | ADDR_W | Line stride in bytes |
| out_oor | output | 1 | Coordinate out of range |

## Verification
The hardest cases to reach are the range boundaries of the narrower formats while mirroring and swap are active. In those cases the XOR with a one-bit-shorter mask and the shifted packing must line up exactly. The stimulus walks all eight orientations on the 16-bit format, where the x and y field widths differ. It also drives coordinates exactly at the mask and one above it in page mode and in 8-bit mode. A back-to-back burst then checks that a result never leaks into the next cycle's slot.

// File: rtl/tile_pkg.sv
package tile_pkg;

    typedef enum logic [1:0] {
        FMT_8  = 2'd0,
        FMT_16 = 2'd1,
        FMT_32 = 2'd2,
        FMT_PG = 2'd3
    } tile_fmt_t;

    typedef struct packed {
        logic swap;
        logic yinv;
        logic xinv;
    } orient_flags_t;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ISSUE = 2'd2
    } gen_state_t;

    function automatic orient_flags_t decode_orient(input logic [2:0] code);
        orient_flags_t f;
        f.swap = code[2];
        f.yinv = code[1];
        f.xinv = code[0];
        return f;
    endfunction

endpackage

// File: rtl/tile_fmt_geom.sv
module tile_fmt_geom
    import tile_pkg::*;
#(
    parameter int CONT_W_BITS = 14,
    parameter int CONT_H_BITS = 13,
    parameter int SLOT_W_BITS = 6,
    parameter int SLOT_H_BITS = 6,
    parameter int SH_W        = 6
) (
    input  tile_fmt_t       fmt_i,
    output logic [SH_W-1:0] xshift_o,
    output logic [SH_W-1:0] yshift_o,
    output logic [SH_W-1:0] xbits_o,
    output logic [SH_W-1:0] ybits_o,
    output logic [SH_W-1:0] scale_o
);
    localparam logic [SH_W-1:0] CW = SH_W'(CONT_W_BITS);
    localparam logic [SH_W-1:0] CH = SH_W'(CONT_H_BITS);

    always_comb begin
        unique case (fmt_i)
            FMT_8:  begin xshift_o = '0;                  yshift_o = '0;                  end
            FMT_16: begin xshift_o = '0;                  yshift_o = SH_W'(1);            end
            FMT_32: begin xshift_o = SH_W'(1);            yshift_o = SH_W'(1);            end
            default: begin xshift_o = SH_W'(SLOT_W_BITS); yshift_o = SH_W'(SLOT_H_BITS); end
        endcase
        xbits_o = CW - xshift_o;
        ybits_o = CH - yshift_o;
        scale_o = xshift_o + yshift_o;
    end
endmodule

// File: rtl/tile_coord_map.sv
module tile_coord_map
    import tile_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int ADDR_W  = 32,
    parameter int SH_W    = 6
) (
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [SH_W-1:0]    xbits_i,
    input  logic [SH_W-1:0]    ybits_i,
    input  logic [SH_W-1:0]    scale_i,
    input  orient_flags_t      flags_i,
    output logic [ADDR_W-1:0]  offset_o,
    output logic               oor_o
);
    logic [ADDR_W-1:0] xmask, ymask;
    logic [ADDR_W-1:0] xe, ye, xm, ym;
    logic [ADDR_W-1:0] packed_off;

    always_comb begin
        xmask      = (ADDR_W'(1) << xbits_i) - ADDR_W'(1);
        ymask      = (ADDR_W'(1) << ybits_i) - ADDR_W'(1);
        xe         = ADDR_W'(x_i);
        ye         = ADDR_W'(y_i);
        oor_o      = (xe > xmask) || (ye > ymask);
        xm         = flags_i.xinv ? (xe ^ xmask) : xe;
        ym         = flags_i.yinv ? (ye ^ ymask) : ye;
        packed_off = flags_i.swap ? ((xm << ybits_i) + ym)
                                  : ((ym << xbits_i) + xm);
        offset_o   = packed_off << scale_i;
    end
endmodule

// File: rtl/tile_stride_calc.sv
module tile_stride_calc #(
    parameter int CONT_W_BITS = 14,
    parameter int CONT_H_BITS = 13,
    parameter int ADDR_W      = 32,
    parameter int SH_W        = 6
) (
    input  logic              swap_i,
    input  logic [SH_W-1:0]   xshift_i,
    input  logic [SH_W-1:0]   yshift_i,
    output logic [ADDR_W-1:0] stride_o
);
    logic [SH_W-1:0] pow;

    always_comb begin
        pow      = swap_i ? (SH_W'(CONT_H_BITS) + xshift_i)
                          : (SH_W'(CONT_W_BITS) + yshift_i);
        stride_o = ADDR_W'(1) << pow;
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tile_pkg::*;
#(
    parameter int CONT_W_BITS = 14,
    parameter int CONT_H_BITS = 13,
    parameter int SLOT_W_BITS = 6,
    parameter int SLOT_H_BITS = 6,
    parameter int COORD_W     = 16,
    parameter int ADDR_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_fmt,
    input  logic [2:0]         in_orient,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [ADDR_W-1:0]  out_stride,
    output logic               out_oor
);
    localparam int SH_W    = $clog2(ADDR_W) + 1;
    localparam int ORI_LSB = ADDR_W - 3;
    localparam int FMT_LSB = ADDR_W - 5;

    gen_state_t        state_q, state_d;
    tile_fmt_t         fmt;
    orient_flags_t     flags;
    logic [SH_W-1:0]   xshift, yshift, xbits, ybits, scale;
    logic [ADDR_W-1:0] offset, stride, addr_d;
    logic              oor;
    logic              accept;

    assign fmt    = tile_fmt_t'(in_fmt);
    assign flags  = decode_orient(in_orient);
    assign accept = in_valid && in_ready;

    tile_fmt_geom #(
        .CONT_W_BITS(CONT_W_BITS), .CONT_H_BITS(CONT_H_BITS),
        .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS), .SH_W(SH_W)
    ) u_geom (
        .fmt_i(fmt), .xshift_o(xshift), .yshift_o(yshift),
        .xbits_o(xbits), .ybits_o(ybits), .scale_o(scale)
    );

    tile_coord_map #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .SH_W(SH_W)) u_map (
        .x_i(in_x), .y_i(in_y), .xbits_i(xbits), .ybits_i(ybits),
        .scale_i(scale), .flags_i(flags), .offset_o(offset), .oor_o(oor)
    );

    tile_stride_calc #(
        .CONT_W_BITS(CONT_W_BITS), .CONT_H_BITS(CONT_H_BITS),
        .ADDR_W(ADDR_W), .SH_W(SH_W)
    ) u_stride (
        .swap_i(flags.swap), .xshift_i(xshift), .yshift_i(yshift),
        .stride_o(stride)
    );

    always_comb begin
        addr_d = '0;
        if (!oor) begin
            addr_d[FMT_LSB-1:0]       = offset[FMT_LSB-1:0];
            addr_d[ORI_LSB-1:FMT_LSB] = in_fmt;
            addr_d[ADDR_W-1:ORI_LSB]  = in_orient;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = ST_IDLE;
            ST_IDLE:  state_d = accept ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = accept ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_stride <= '0;
            out_oor    <= 1'b0;
        end else if (accept) begin
            out_addr   <= addr_d;
            out_stride <= stride;
            out_oor    <= oor;
        end
    end

    assign in_ready  = (state_q != ST_INIT) && rst_n;
    assign out_valid = (state_q == ST_ISSUE);
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
    parameter int COORD_W = 16,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [1:0]         in_fmt,
    input logic [2:0]         in_orient,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [ADDR_W-1:0]  out_stride,
    input logic               out_oor
);
    assert_valid_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid && in_ready) |-> ($stable(out_addr) && $stable(out_stride) && $stable(out_oor)));

    assert_oor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_oor) |-> (out_addr == '0));

    assert_fmt_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_oor) |-> (out_addr[ADDR_W-4:ADDR_W-5] == $past(in_fmt)));

    assert_orient_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_oor) |-> (out_addr[ADDR_W-1:ADDR_W-3] == $past(in_orient)));

    assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_stride) == 1));
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_orient(in_orient), .out_valid(out_valid),
    .out_addr(out_addr), .out_stride(out_stride), .out_oor(out_oor)
);

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_orient = '0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_stride;
    logic        out_oor;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_addr(out_addr), .out_stride(out_stride),
        .out_oor(out_oor)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference from the requirements (R3..R9)
    function automatic logic [31:0] ref_addr(input int f, input int o, input int xi, input int yi,
                                             output logic oor, output logic [31:0] strd);
        int xs, ys, xb, yb;
        logic [31:0] xm, ym, x, y, off;
        case (f)
            0: begin xs = 0; ys = 0; end
            1: begin xs = 0; ys = 1; end
            2: begin xs = 1; ys = 1; end
            default: begin xs = 6; ys = 6; end
        endcase
        xb = 14 - xs; yb = 13 - ys;
        xm = (32'd1 << xb) - 1; ym = (32'd1 << yb) - 1;
        x = 32'(xi); y = 32'(yi);
        oor = (x > xm) || (y > ym);
        if (o & 1) x = x ^ xm;
        if (o & 2) y = y ^ ym;
        off = (o & 4) ? ((x << yb) + y) : ((y << xb) + x);
        off = off << (xs + ys);
        strd = (o & 4) ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
        return oor ? 32'd0 : (off | (32'(o) << 29) | (32'(f) << 27));
    endfunction

    task automatic drive(input int f, input int o, input int x, input int y);
        in_valid  = 1'b1;
        in_fmt    = 2'(f);
        in_orient = 3'(o);
        in_x      = 16'(x);
        in_y      = 16'(y);
    endtask

    task automatic expect_out(input string req, input int f, input int o, input int x, input int y);
        logic oor; logic [31:0] s; logic [31:0] a;
        a = ref_addr(f, o, x, y, oor, s);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " addr"}, out_addr, a);
        check({req, " stride R9"}, out_stride, s);
        check({req, " oor"}, 32'(out_oor), 32'(oor));
    endtask

    // one request, check result, then check hold (R10)
    task automatic t_single(input string req, input int f, input int o, input int x, input int y);
        logic [31:0] a;
        @(negedge clk); drive(f, o, x, y);
        @(negedge clk); in_valid = 1'b0;
        expect_out(req, f, o, x, y);
        a = out_addr;
        @(negedge clk);
        check("R10 valid drops", 32'(out_valid), 32'd0);
        check("R10 addr held", out_addr, a);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", 32'(in_ready), 32'd0);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 addr in reset", out_addr, 32'd0);
        check("R1 stride in reset", out_stride, 32'd0);
        check("R1 oor in reset", 32'(out_oor), 32'd0);
        rst_n = 1'b1;
        check("R1 ready first cycle", 32'(in_ready), 32'd0);
        @(negedge clk);
        check("R1 ready after", 32'(in_ready), 32'd1);
        check("R1 valid after", 32'(out_valid), 32'd0);
    endtask

    task automatic t_literals;
        @(negedge clk); drive(0, 0, 5, 3);
        @(negedge clk); in_valid = 1'b0;
        check("R7 plain pack", out_addr, 32'h0000C005);
        @(negedge clk); drive(3, 0, 1, 0);
        @(negedge clk); in_valid = 1'b0;
        check("R8 page scale", out_addr, 32'h18001000);
        check("R9 page stride", out_stride, 32'h00100000);
    endtask

    task automatic t_formats;
        for (int f = 0; f < 4; f++) t_single("R2 R4 format", f, 0, 9, 4);
    endtask

    task automatic t_orients;
        for (int o = 0; o < 8; o++) t_single("R3 R6 R7 orient", 1, o, 16'h0123, 16'h0045);
        t_single("R7 R8 swap 32bit", 2, 6, 16'h0AB1, 16'h0321);
        t_single("R6 page mirror", 3, 7, 16'h0011, 16'h0007);
    endtask

    task automatic t_range;
        t_single("R5 x at mask", 0, 0, 16'h3FFF, 16'h1FFF);
        t_single("R5 x over", 0, 0, 16'h4000, 0);
        t_single("R5 y over 16bit", 1, 1, 0, 16'h1000);
        t_single("R5 page at mask", 3, 3, 16'h00FF, 16'h007F);
        t_single("R5 page over", 3, 4, 16'h0100, 0);
        @(negedge clk); drive(0, 0, 16'hFFFF, 0);
        @(negedge clk); in_valid = 1'b0;
        check("R5 zero addr", out_addr, 32'd0);
        check("R5 flag", 32'(out_oor), 32'd1);
    endtask

    task automatic t_burst;
        @(negedge clk); drive(0, 2, 100, 200);
        @(negedge clk); expect_out("R11 burst 0", 0, 2, 100, 200); drive(2, 5, 300, 400);
        @(negedge clk); expect_out("R11 burst 1", 2, 5, 300, 400); drive(3, 6, 20, 30);
        @(negedge clk); expect_out("R11 burst 2", 3, 6, 20, 30); in_valid = 1'b0;
        @(negedge clk);
        check("R11 end valid", 32'(out_valid), 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_literals();
        t_formats();
        t_orients();
        t_range();
        t_burst();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule